// File: doc/BRIEF.md
# MDIO Management Master with Command Register

This block drives a two-wire management bus (MDC clock, bidirectional MDIO data) toward one or more Ethernet PHYs. It is controlled through one 32-bit command/status word. Software writes a word with the busy bit set, and that write starts a transaction. The word carries the PHY port, a register or device address, an opcode, a start-type selector and a 16-bit payload. The block then sends one complete management frame, in either the short-start (Clause 22) or the extended-start (Clause 45) form. When the frame ends, the block clears busy. For read-type frames, the block also puts the 16 bits sampled from the bus into the low half of the same word.

A Clause 45 access takes two commands in sequence. The first is an address frame whose payload is the target register number. The second is a write, read or read-with-increment frame to the same port and device. MDC runs only while a frame is in flight. Its rate comes from the system clock through a parameterized divider whose default gives 2.5 MHz from 200 MHz.

The command port has no back-pressure. The block accepts a write only when the word has bit 31 set and the block is idle. Every other write is dropped without any effect. Software polls bit 31 (busy) or bit 30 (ready) before it issues the next command. The read port is a plain, always-valid view of the word.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the status word reads 0x4000_0000 (busy 0, ready 1, all other bits 0), MDC is low and the MDIO output enable is low.
- R2: A write with bit 31 set while idle starts a frame. From the next cycle until the frame ends, bit 31 reads 1 and bit 30 reads 0. At the end, bit 31 returns to 0 and bit 30 to 1.
- R3: A write with bit 31 clear, or any write while busy, is ignored. The status word does not change, no frame is started and the frame in flight continues unchanged.
- R4: Each frame is 64 MDC cycles, sent MSB first in this order: 32 ones, a 2-bit start, the opcode (bits 19:18 sent verbatim), the port (bits 24:20), the register/device address (bits 29:25), a 2-bit turnaround and 16 data bits. The start is 01 when bits 17:16 equal 1 and 00 for any other value.
- R5: When opcode bit 19 is 0 (write or address type), the master drives all 64 bit times. The turnaround is sent as 1 then 0, and the data field is sent as bits 15:0 of the command.
- R6: When opcode bit 19 is 1 (read or read-with-increment), the master releases MDIO for bit times 46 to 63 (turnaround and data). It samples the 16 data bits on MDC rising edges, and when busy clears, bits 15:0 hold the sampled value, first sample in bit 15.
- R7: A read that no PHY answers returns 0xFFFF (idle-high bus), never the result of an earlier read.
- R8: MDC is low for the first half and high for the second half of every bit time, each half lasting CLK_HZ/(2*MDC_HZ) clocks. MDIO output and output enable change only at the falling edge. MDC stays low while idle.
- R9: Bits 29:16 of the status word hold the fields of the last accepted command, from the cycle after it is accepted until another command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word to write |
| rd_data | output | 32 | Status word: busy, ready, fields, data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value sampled from the pad |

## Verification
A PHY model on the bench answers reads only at one port address. It reads from an undriven, pulled-up line for every other port. A read to an absent port right after a read that returned 0x7500 therefore shows whether the capture path keeps stale data: a faulty design would report 0x7500 again. The bench records the drive-enable pattern at every MDC rising edge. A design that released MDIO one bit early or late, or that drove the turnaround of a read, fails the mask comparison. A second command written mid-frame, and a command without bit 31, must leave the frame and the status word unchanged. A design that re-launched would produce an extra frame or different echoed fields. The bench also checks the start encoding for a selector value other than 0 or 1, and measures the MDC high and low widths in system clocks.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  typedef struct packed {
    logic [4:0] regdev;
    logic [4:0] port;
    logic [1:0] op;
    logic [1:0] st;
  } cmd_fields_t;

  function automatic logic is_read_op(input cmd_fields_t c);
    return c.op[1];
  endfunction

  function automatic logic [FRAME_BITS-1:0] make_frame(input cmd_fields_t c,
                                                       input logic [15:0] d);
    logic [1:0]  start;
    logic [1:0]  ta;
    logic [15:0] payload;
    start   = {1'b0, (c.st == 2'd1)};
    ta      = is_read_op(c) ? 2'b11 : 2'b10;
    payload = is_read_op(c) ? 16'hFFFF : d;
    return {32'hFFFF_FFFF, start, c.op, c.port, c.regdev, ta, payload};
  endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int HALF = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          phase;
  logic          wrap;

  assign wrap      = run && (cnt == CW'(HALF - 1));
  assign rise_tick = wrap && !phase;
  assign fall_tick = wrap && phase;
  assign mdc       = phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rd_in,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rd_value
);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [IW-1:0]         idx;
  logic                  active;
  logic                  rd_mode;
  logic [15:0]           cap;
  logic                  last_bit;
  logic                  in_release;

  assign last_bit   = (idx == IW'(FRAME_BITS - 1));
  assign in_release = rd_mode && (idx >= IW'(TA_POS));
  assign done       = active && fall_tick && last_bit;
  assign mdio_o     = active ? shreg[FRAME_BITS-1] : 1'b1;
  assign mdio_oe    = active && !in_release;
  assign rd_value   = cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '1;
      idx     <= '0;
      active  <= 1'b0;
      rd_mode <= 1'b0;
      cap     <= 16'hFFFF;
    end else if (load) begin
      shreg   <= frame_in;
      idx     <= '0;
      active  <= 1'b1;
      rd_mode <= rd_in;
      cap     <= 16'hFFFF;
    end else if (active) begin
      if (rise_tick && rd_mode && (idx >= IW'(DATA_POS)))
        cap <= {cap[14:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          active <= 1'b0;
        end else begin
          shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
          idx   <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        done,
  input  logic [15:0] rd_value,
  output logic        launch,
  output logic        busy,
  output logic [31:0] rd_data
);
  cmd_fields_t fields;
  cmd_fields_t wr_fields;
  logic [15:0] data;
  logic        unused_bit;

  assign unused_bit = wr_data[30];
  assign wr_fields  = cmd_fields_t'(wr_data[29:16]);
  assign launch     = wr_en && wr_data[31] && !busy;
  assign rd_data    = {busy, ~busy, fields, data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fields <= '0;
      data   <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      fields <= wr_fields;
      data   <= is_read_op(wr_fields) ? 16'hFFFF : wr_data[15:0];
    end else if (done) begin
      busy <= 1'b0;
      if (is_read_op(fields))
        data <= rd_value;
    end
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int MDC_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF_RAW = CLK_HZ / (2 * MDC_HZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic                  launch;
  logic                  busy;
  logic                  done;
  logic                  rise_tick;
  logic                  fall_tick;
  logic [15:0]           rd_value;
  logic [FRAME_BITS-1:0] frame_in;
  cmd_fields_t           new_fields;

  assign new_fields = cmd_fields_t'(wr_data[29:16]);
  assign frame_in   = make_frame(new_fields, wr_data[15:0]);

  mdio_cmd_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .done     (done),
    .rd_value (rd_value),
    .launch   (launch),
    .busy     (busy),
    .rd_data  (rd_data)
  );

  mdio_clk_gen #(.HALF(HALF)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .frame_in  (frame_in),
    .rd_in     (is_read_op(new_fields)),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rd_value  (rd_value)
  );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |-> (!mdio_oe && !mdc)) else $error("idle bus not quiet"); // R1

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[31] && wr_en && wr_data[31]) |=> (rd_data[31] && !rd_data[30])) else $error("launch missed"); // R2

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && wr_en) |=> $stable(rd_data[29:16])) else $error("write during busy took effect"); // R3

  AST_NOLAUNCH_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[31] && wr_en && !wr_data[31]) |=> $stable(rd_data)) else $error("write without busy bit took effect"); // R3

  AST_HOLD_WHILE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))) else $error("MDIO changed while MDC high"); // R8
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_cmd_master.sv
`timescale 1ns/1ps
module sim_mdio_cmd_master;
  localparam int CLK_HZ = 200_000_000;
  localparam int MDC_HZ = 25_000_000;
  localparam int HALF   = CLK_HZ / (2 * MDC_HZ);
  localparam logic [4:0] PHY_PORT = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_cmd_master #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int vectors = 0;
  int miscompares = 0;
  bit reported = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // PHY model: answers reads at PHY_PORT only, bus is pulled high otherwise
  logic [15:0] phy_val = 16'h7500;
  int   rcount = 0;
  logic obs_o  [64];
  logic obs_oe [64];
  logic [4:0] seen_port;

  always @(posedge mdc) begin
    if (rcount < 64) begin
      obs_o[rcount]  = mdio_o;
      obs_oe[rcount] = mdio_oe;
    end
    rcount++;
  end

  always @(negedge mdc) begin
    seen_port = {obs_o[36], obs_o[37], obs_o[38], obs_o[39], obs_o[40]};
    if (rcount >= 48 && rcount < 64 && obs_o[34] && seen_port == PHY_PORT)
      mdio_i = phy_val[63 - rcount];
    else
      mdio_i = 1'b1;
  end

  // scoreboard
  logic [63:0] q_frame[$];
  logic [63:0] q_mask[$];
  logic [31:0] q_reg[$];
  string       q_tag[$];
  int frames_sent = 0;
  int frames_seen = 0;

  task automatic compare_frame();
    logic [63:0] ov, oev, fr, mk;
    logic [31:0] rg;
    string tg;
    frames_seen++;
    if (q_frame.size() == 0) begin
      check(0, "R3", 64'(frames_seen), 64'(frames_sent), "unexpected frame");
      return;
    end
    fr = q_frame.pop_front(); mk = q_mask.pop_front();
    rg = q_reg.pop_front();   tg = q_tag.pop_front();
    for (int i = 0; i < 64; i++) begin
      ov[63-i]  = obs_o[i];
      oev[63-i] = obs_oe[i];
    end
    check((ov & mk) == (fr & mk), tg, ov & mk, fr & mk, "frame bits (R4)");
    check(oev == mk, tg, oev, mk, "drive mask");
    check(rcount == 64, "R4", 64'(rcount), 64'd64, "MDC cycles per frame");
    check(rd_data == rg, tg, 64'(rd_data), 64'(rg), "status after frame");
  endtask

  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (prev && !rd_data[31]) compare_frame();
      prev = rd_data[31];
    end
  end

  task automatic issue(input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] port, input logic [4:0] rdv,
                       input logic [15:0] d, input string tag);
    logic [31:0] w;
    logic        rdop;
    logic [15:0] res;
    w    = {1'b1, 1'b0, rdv, port, op, st, d};
    rdop = op[1];
    res  = rdop ? ((port == PHY_PORT) ? phy_val : 16'hFFFF) : d;
    q_frame.push_back({32'hFFFF_FFFF, 1'b0, (st == 2'b01), op, port, rdv,
                       rdop ? 2'b00 : 2'b10, rdop ? 16'h0000 : d});
    q_mask.push_back(rdop ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF);
    q_reg.push_back({1'b0, 1'b1, w[29:16], res});
    q_tag.push_back(tag);
    frames_sent++;
    @(negedge clk);
    rcount  = 0;
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data[31:30] == 2'b10, "R2", 64'(rd_data[31:30]), 64'd2, "busy/ready after launch");
    check(rd_data[29:16] == w[29:16], "R9", 64'(rd_data[29:16]), 64'(w[29:16]), "echoed fields");
  endtask

  task automatic wait_idle();
    while (rd_data[31]) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 64'(cyc), 64'd0, "run did not finish");
    report();
  end

  initial begin
    int t1, tf, t2, rc;
    logic [31:0] saved;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 32'h4000_0000, "R1", 64'(rd_data), 64'h4000_0000, "reset word");
    check(mdc == 1'b0, "R1", 64'(mdc), 64'd0, "reset MDC");
    check(mdio_oe == 1'b0, "R1", 64'(mdio_oe), 64'd0, "reset output enable");

    // short-start write, with MDC timing measured in flight
    issue(2'b01, 2'b01, PHY_PORT, 5'd5, 16'hA5C3, "R5");
    @(posedge mdc); t1 = cyc;
    @(negedge mdc); tf = cyc;
    @(posedge mdc); t2 = cyc;
    check(t2 - t1 == 2 * HALF, "R8", 64'(t2 - t1), 64'(2 * HALF), "MDC period");
    check(tf - t1 == HALF, "R8", 64'(tf - t1), 64'(HALF), "MDC high width");
    wait_idle();

    // short-start read, answered
    issue(2'b01, 2'b10, PHY_PORT, 5'd2, 16'h0000, "R6");
    wait_idle();
    // short-start read of an absent port after a real answer
    issue(2'b01, 2'b10, 5'h1F, 5'd2, 16'h0000, "R7");
    wait_idle();

    // extended-start sequence: address, write, read, read-increment
    issue(2'b00, 2'b00, PHY_PORT, 5'd1, 16'h1234, "R4");
    wait_idle();
    issue(2'b00, 2'b01, PHY_PORT, 5'd1, 16'hBEEF, "R5");
    wait_idle();
    phy_val = 16'h1C2D;
    issue(2'b00, 2'b11, PHY_PORT, 5'd1, 16'h0000, "R6");
    wait_idle();
    phy_val = 16'h8001;
    issue(2'b00, 2'b10, PHY_PORT, 5'd7, 16'h0000, "R6");
    wait_idle();
    issue(2'b00, 2'b11, 5'd9, 5'd1, 16'h0000, "R7");
    wait_idle();

    // selector value other than 0 or 1 gives the 00 start
    issue(2'b11, 2'b01, 5'd4, 5'd30, 16'h5A5A, "R4");
    wait_idle();

    // second command during a frame is dropped
    issue(2'b01, 2'b01, PHY_PORT, 5'd7, 16'h0F0F, "R5");
    repeat (60) @(negedge clk);
    wr_en = 1'b1; wr_data = {1'b1, 1'b0, 5'd12, 5'd20, 2'b10, 2'b01, 16'h1111};
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data[29:16] == {5'd7, PHY_PORT, 2'b01, 2'b01}, "R3",
          64'(rd_data[29:16]), 64'({5'd7, PHY_PORT, 2'b01, 2'b01}), "fields after busy write");
    wait_idle();
    repeat (20) @(negedge clk);
    check(frames_seen == frames_sent, "R3", 64'(frames_seen), 64'(frames_sent), "frame count after busy write");

    // write without bit 31 while idle
    saved = rd_data; rc = rcount;
    wr_en = 1'b1; wr_data = 32'h3FFF_1234;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (40) @(negedge clk);
    check(rd_data == saved, "R3", 64'(rd_data), 64'(saved), "word after write without busy bit");
    check(rcount == rc, "R3", 64'(rcount), 64'(rc), "MDC edges after write without busy bit");

    check(q_frame.size() == 0, "R2", 64'(q_frame.size()), 64'd0, "pending expected frames");
    report();
  end
endmodule